// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits beside a first-level cache and reduces the cost of misses on sequential access patterns. When the cache misses and no stream head matches, the block takes over its least recently used stream, points it at the line after the miss, and fetches that line and the ones after it from the next memory level. The fetched lines stay in the stream's own small FIFO and are never written into the cache by the block. A later cache miss is compared against every stream head. On a match the head line is handed back, the head is popped, and the freed slot is refilled with the line that follows the current tail.

Several streams run side by side, so interleaved sequential walks can each keep their own stream. The next memory level is pipelined and accepts a new request every cycle without waiting for earlier data. Responses come back in request order. A small queue records which stream and slot each outstanding request belongs to. If a stream is taken over while its fetches are still in flight, the responses for its old contents are counted off and thrown away.

The cache presents a line address with `lk_valid_i` and holds it until `lk_done_o` rises. Line addresses count lines, so the next line is the address plus one.

Top module: `sb_stream_buf`

## Requirements
- R1: After reset no stream holds lines, `mem_req_o` is low, and the first lookup reports a miss.
- R2: A lookup that matches no valid stream head completes in the same cycle with `lk_hit_o` low. The least recently used stream is reloaded with line addresses A+1 to A+DEPTH (A is the lookup address), and these lines are requested from memory in ascending order.
- R3: A lookup that matches a stream head whose data has arrived completes in the same cycle with `lk_hit_o` high. `lk_data_o` carries the word memory returned for that line address.
- R4: After a head hit, the head moves to the next line. The next request issued for that stream is the hit address plus DEPTH, which is one past the old tail.
- R5: Only stream heads are compared. A lookup whose line sits in a non-head slot counts as a miss and reloads a stream.
- R6: A lookup that matches a head whose fetch is still outstanding holds `lk_done_o` low. It completes, as a hit, in the cycle after the one in which the matching response is presented.
- R7: Memory requests keep being issued while earlier ones are unanswered, up to 2*NS*DEPTH outstanding. Each in-order response is written into the stream and slot recorded when it was issued.
- R8: The victim of a reload is the stream whose last hit or reload is oldest. Out of reset the streams are taken in the order NS-1, NS-2, ..., 0.
- R9: When a stream is reloaded while its fetches are outstanding, the responses to those old fetches are discarded. The new lines receive only the data of their own addresses.
- R10: While `mem_req_o` is high and `mem_gnt_i` low, and no lookup completes, the request and `mem_addr_o` stay unchanged in the next cycle.
- R11: `lk_done_o` is high only while `lk_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Cache miss lookup request, held until done |
| lk_addr_i | input | AW | Line address of the cache miss |
| lk_done_o | output | 1 | Lookup completes this cycle |
| lk_hit_o | output | 1 | Completed lookup found the line at a stream head |
| lk_data_o | output | DW | Line data on a hit, zero otherwise |
| mem_req_o | output | 1 | Read request to the next level |
| mem_addr_o | output | AW | Line address of the read request |
| mem_gnt_i | input | 1 | Next level accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read response valid, in request order |
| mem_rdata_i | input | DW | Read response data |

## Verification
The two functions that meet in one cycle are a stream reload and a memory response that still belongs to that stream's old contents. To provoke it, the bench sets a long memory latency and makes three quick misses with two streams, so the third miss takes over a stream whose four fetches have not yet returned. The bench then looks up the new lines and expects each to stall until its own response. It requires each to return the data of its own address, so any stale word that lands in a slot shows up as a wrong value or an early completion. A second overlap, a response arriving while a lookup waits on that same pending head, is judged by the exact gap of one cycle between the response and `lk_done_o`.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_HIT,
    LK_STALL,
    LK_MISS
  } lk_res_e;

  function automatic int unsigned clog2_min1(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sb_lru.sv
module sb_lru #(
  parameter int NS = 2,
  localparam int NSW = sb_pkg::clog2_min1(NS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           touch_i,
  input  logic [NSW-1:0] touch_id_i,
  output logic [NSW-1:0] victim_o
);

  // rank 0 = most recent, NS-1 = least recent
  logic [NSW-1:0] rank [NS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) rank[i] <= NSW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NS; i++) begin
        if (NSW'(i) == touch_id_i)            rank[i] <= '0;
        else if (rank[i] < rank[touch_id_i]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NS; i++)
      if (rank[i] == NSW'(NS - 1)) victim_o = NSW'(i);
  end

endmodule

// File: rtl/sb_tagq.sv
module sb_tagq #(
  parameter int W     = 3,
  parameter int DEPTH = 16,
  localparam int PW = sb_pkg::clog2_min1(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rp];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= data_i;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/sb_stream.sv
module sb_stream #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int SW = sb_pkg::clog2_min1(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic          pop_i,
  input  logic          iss_i,
  input  logic          fill_i,
  input  logic [SW-1:0] fill_slot_i,
  input  logic [DW-1:0] fill_data_i,
  output logic          vld_o,
  output logic [AW-1:0] head_tag_o,
  output logic          head_rdy_o,
  output logic [DW-1:0] head_data_o,
  output logic          iss_req_o,
  output logic [AW-1:0] iss_addr_o,
  output logic [SW-1:0] iss_slot_o
);

  logic             vld;
  logic [SW-1:0]    hp;
  logic [AW-1:0]    tag  [DEPTH];
  logic [DW-1:0]    data [DEPTH];
  logic [DEPTH-1:0] rdy;   // data arrived
  logic [DEPTH-1:0] isd;   // request issued
  logic [SW-1:0]    hp_nxt;

  assign hp_nxt = (hp == SW'(DEPTH - 1)) ? '0 : hp + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld <= 1'b0;
      hp  <= '0;
      rdy <= '0;
      isd <= '0;
      for (int k = 0; k < DEPTH; k++) tag[k] <= '0;
    end else if (alloc_i) begin
      vld <= 1'b1;
      hp  <= '0;
      rdy <= '0;
      isd <= '0;
      for (int k = 0; k < DEPTH; k++) tag[k] <= alloc_addr_i + AW'(k + 1);
    end else begin
      if (iss_i)  isd[iss_slot_o] <= 1'b1;
      if (fill_i) rdy[fill_slot_i] <= 1'b1;
      if (pop_i) begin
        // freed head slot becomes the new tail: one past the old tail
        tag[hp] <= tag[hp] + AW'(DEPTH);
        rdy[hp] <= 1'b0;
        isd[hp] <= 1'b0;
        hp      <= hp_nxt;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !alloc_i) data[fill_slot_i] <= fill_data_i;
  end

  // oldest unissued slot in FIFO order
  always_comb begin
    logic [SW-1:0] idx;
    iss_req_o  = 1'b0;
    iss_slot_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      idx = SW'((int'(hp) + k) % DEPTH);
      if (!isd[idx]) begin
        iss_req_o  = vld;
        iss_slot_o = idx;
      end
    end
  end

  assign iss_addr_o  = tag[iss_slot_o];
  assign vld_o       = vld;
  assign head_tag_o  = tag[hp];
  assign head_rdy_o  = rdy[hp];
  assign head_data_o = data[hp];

endmodule

// File: rtl/sb_stream_buf.sv
module sb_stream_buf
  import sb_pkg::*;
#(
  parameter int NS    = 2,
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_done_o,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);

  localparam int NSW = clog2_min1(NS);
  localparam int SW  = clog2_min1(DEPTH);
  localparam int TQ  = 2 * NS * DEPTH;
  localparam int TW  = NSW + SW;
  localparam int CW  = $clog2(TQ + 1);

  logic [NS-1:0] vld, head_rdy, iss_req, iss_go, pop, alloc, fill, hit_vec;
  logic [AW-1:0] head_tag  [NS];
  logic [DW-1:0] head_data [NS];
  logic [AW-1:0] iss_addr  [NS];
  logic [SW-1:0] iss_slot  [NS];
  logic [CW-1:0] out_cnt   [NS];
  logic [CW-1:0] drop_cnt  [NS];

  logic [NS*AW-1:0] head_tag_flat;
  logic [NS*CW-1:0] out_flat, drop_flat;

  logic           hit_any, iss_any, grant;
  logic [NSW-1:0] hit_sel, iss_sel, victim, touch_id;
  lk_res_e        lk_res;

  logic           tq_full, tq_empty;
  logic [TW-1:0]  tq_din, tq_dout;
  logic [NSW-1:0] rsp_strm;
  logic [SW-1:0]  rsp_slot;

  // ---------------- lookup ----------------
  always_comb begin
    hit_any = 1'b0;
    hit_sel = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (hit_vec[s]) begin
        hit_any = 1'b1;
        hit_sel = NSW'(s);
      end
    end
  end

  always_comb begin
    if (!lk_valid_i)            lk_res = LK_IDLE;
    else if (!hit_any)          lk_res = LK_MISS;
    else if (head_rdy[hit_sel]) lk_res = LK_HIT;
    else                        lk_res = LK_STALL;
  end

  assign lk_done_o = (lk_res == LK_HIT) || (lk_res == LK_MISS);
  assign lk_hit_o  = (lk_res == LK_HIT);
  assign lk_data_o = (lk_res == LK_HIT) ? head_data[hit_sel] : '0;
  assign touch_id  = (lk_res == LK_HIT) ? hit_sel : victim;

  sb_lru #(.NS(NS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (lk_done_o),
    .touch_id_i (touch_id),
    .victim_o   (victim)
  );

  // ---------------- request issue ----------------
  always_comb begin
    iss_any = 1'b0;
    iss_sel = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (iss_req[s]) begin
        iss_any = 1'b1;
        iss_sel = NSW'(s);
      end
    end
  end

  assign mem_req_o  = iss_any && !tq_full;
  assign mem_addr_o = iss_addr[iss_sel];
  assign grant      = mem_req_o && mem_gnt_i;
  assign tq_din     = {iss_sel, iss_slot[iss_sel]};
  assign {rsp_strm, rsp_slot} = tq_dout;

  sb_tagq #(.W(TW), .DEPTH(TQ)) u_tagq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (grant),
    .data_i  (tq_din),
    .pop_i   (mem_rvalid_i),
    .data_o  (tq_dout),
    .full_o  (tq_full),
    .empty_o (tq_empty)
  );

  // ---------------- streams ----------------
  for (genvar s = 0; s < NS; s++) begin : g_strm
    logic          rsp_here;
    logic [CW-1:0] out_nxt;

    assign hit_vec[s] = lk_valid_i && vld[s] && (head_tag[s] == lk_addr_i);
    assign pop[s]     = (lk_res == LK_HIT) && (hit_sel == NSW'(s));
    assign alloc[s]   = (lk_res == LK_MISS) && (victim == NSW'(s));
    assign iss_go[s]  = grant && (iss_sel == NSW'(s));
    assign rsp_here   = mem_rvalid_i && !tq_empty && (rsp_strm == NSW'(s));
    assign fill[s]    = rsp_here && (drop_cnt[s] == '0);
    assign out_nxt    = out_cnt[s] + CW'(iss_go[s]) - CW'(rsp_here);

    // responses still owed to this stream; on reload all become stale
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_cnt[s]  <= '0;
        drop_cnt[s] <= '0;
      end else begin
        out_cnt[s] <= out_nxt;
        if (alloc[s])                           drop_cnt[s] <= out_nxt;
        else if (rsp_here && drop_cnt[s] != '0) drop_cnt[s] <= drop_cnt[s] - 1'b1;
      end
    end

    sb_stream #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_stream (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc[s]),
      .alloc_addr_i (lk_addr_i),
      .pop_i        (pop[s]),
      .iss_i        (iss_go[s]),
      .fill_i       (fill[s]),
      .fill_slot_i  (rsp_slot),
      .fill_data_i  (mem_rdata_i),
      .vld_o        (vld[s]),
      .head_tag_o   (head_tag[s]),
      .head_rdy_o   (head_rdy[s]),
      .head_data_o  (head_data[s]),
      .iss_req_o    (iss_req[s]),
      .iss_addr_o   (iss_addr[s]),
      .iss_slot_o   (iss_slot[s])
    );

    assign head_tag_flat[s*AW +: AW] = head_tag[s];
    assign out_flat[s*CW +: CW]      = out_cnt[s];
    assign drop_flat[s*CW +: CW]     = drop_cnt[s];
  end

endmodule

// File: rtl/sb_stream_buf_chk.sv
module sb_stream_buf_chk #(
  parameter int NS = 2,
  parameter int AW = 16,
  parameter int CW = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic [AW-1:0]    lk_addr_i,
  input logic             lk_done_o,
  input logic             lk_hit_o,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_gnt_i,
  input logic             mem_rvalid_i,
  input logic [NS-1:0]    vld_i,
  input logic             tq_empty_i,
  input logic [NS*AW-1:0] head_tag_i,
  input logic [NS*CW-1:0] out_i,
  input logic [NS*CW-1:0] drop_i
);

  logic [AW-1:0] miss_next;
  logic          head_match, drop_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       miss_next <= '0;
    else if (lk_done_o && !lk_hit_o)   miss_next <= lk_addr_i + 1'b1;
  end

  always_comb begin
    head_match = 1'b0;
    drop_ok    = 1'b1;
    for (int s = 0; s < NS; s++) begin
      if (vld_i[s] && head_tag_i[s*AW +: AW] == miss_next) head_match = 1'b1;
      if (drop_i[s*CW +: CW] > out_i[s*CW +: CW])          drop_ok    = 1'b0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i == '0) |-> (tq_empty_i && !mem_req_o));

  // R2
  miss_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |=> head_match);

  // R7
  rsp_tracked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> !tq_empty_i);

  // R9
  drop_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_ok);

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !lk_done_o) |=> (mem_req_o && $stable(mem_addr_o)));

  // R11
  done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_done_o |-> lk_valid_i);

endmodule

bind sb_stream_buf sb_stream_buf_chk #(.NS(NS), .AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_valid_i   (lk_valid_i),
  .lk_addr_i    (lk_addr_i),
  .lk_done_o    (lk_done_o),
  .lk_hit_o     (lk_hit_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .vld_i        (vld),
  .tq_empty_i   (tq_empty),
  .head_tag_i   (head_tag_flat),
  .out_i        (out_flat),
  .drop_i       (drop_flat)
);

// File: tb/sb_stream_buf_bench.sv
module sb_stream_buf_bench;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lk_valid_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0;
  logic          lk_done_o, lk_hit_o;
  logic [DW-1:0] lk_data_o;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_gnt_i = 1'b0;
  logic          mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done_flag = 0;

  // memory model state
  logic [AW-1:0] qa [256];
  int            qd [256];
  int            qh = 0, qt = 0, maxq = 0;
  logic [AW-1:0] glog [1024];
  int            gcount = 0;
  int            lat = 3;
  bit            gnt_en = 1;
  logic [AW-1:0] watch_addr = '1;
  int            watch_cyc = -1;
  bit            lk_timeout;

  // {expected hit, line address}; two streams, depth four
  localparam logic [AW:0] VEC [NV] = '{
    {1'b0, 16'd100}, {1'b1, 16'd101}, {1'b1, 16'd102}, {1'b0, 16'd200},
    {1'b1, 16'd103}, {1'b1, 16'd201}, {1'b1, 16'd104}, {1'b1, 16'd105},
    {1'b0, 16'd203}, {1'b1, 16'd106}, {1'b1, 16'd204}, {1'b0, 16'd300},
    {1'b0, 16'd107}, {1'b1, 16'd301}, {1'b1, 16'd108}
  };

  sb_stream_buf u_sb_stream_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_valid_i   (lk_valid_i),
    .lk_addr_i    (lk_addr_i),
    .lk_done_o    (lk_done_o),
    .lk_hit_o     (lk_hit_o),
    .lk_data_o    (lk_data_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a);
    return {a ^ 16'hA5A5, a};
  endfunction

  // pipelined in-order memory: drive at negedge, sample handshakes 4 ns later
  initial begin
    forever begin
      @(negedge clk_i);
      mem_gnt_i = gnt_en;
      if (qt != qh && qd[qh % 256] <= cyc) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = line_data(qa[qh % 256]);
        if (qa[qh % 256] == watch_addr) watch_cyc = cyc;
      end else begin
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
      end
      #4;
      if (rst_ni) begin
        if (mem_rvalid_i) qh++;
        if (mem_req_o && mem_gnt_i) begin
          qa[qt % 256] = mem_addr_o;
          qd[qt % 256] = cyc + lat;
          qt++;
          glog[gcount % 1024] = mem_addr_o;
          gcount++;
        end
        if (qt - qh > maxq) maxq = qt - qh;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    lk_valid_i = 1'b0;
    qh = 0; qt = 0; maxq = 0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, output logic hit,
                           output logic [DW-1:0] data, output int dcyc);
    int waited;
    waited = 0;
    lk_timeout = 0;
    @(negedge clk_i);
    lk_valid_i = 1'b1;
    lk_addr_i  = a;
    forever begin
      #4;
      if (lk_done_o) break;
      waited++;
      if (waited > 400) begin
        lk_timeout = 1;
        break;
      end
      @(negedge clk_i);
    end
    hit  = lk_hit_o;
    data = lk_data_o;
    dcyc = cyc;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
  endtask

  initial begin
    logic          h;
    logic [DW-1:0] d;
    int            dc, g0;

    do_reset();

    // R1: reset state
    #4;
    check(mem_req_o == 1'b0, "R1", "no request after reset", mem_req_o, 0);
    // R11: no completion without a request
    check(lk_done_o == 1'b0, "R11", "done while idle", lk_done_o, 0);

    // vector table: interleaved streams, LRU reloads (R3 R4 R5 R8)
    for (int i = 0; i < NV; i++) begin
      do_lookup(VEC[i][AW-1:0], h, d, dc);
      check(!lk_timeout, "R6", "lookup completes", lk_timeout, 0);
      check(h == VEC[i][AW], VEC[i][AW] ? "R3" : "R8", $sformatf("hit flag vec %0d", i),
            h, VEC[i][AW]);
      if (VEC[i][AW])
        check(d == line_data(VEC[i][AW-1:0]), "R3", $sformatf("data vec %0d", i),
              d, line_data(VEC[i][AW-1:0]));
      else
        check(d == '0, "R2", $sformatf("miss data vec %0d", i), d, 0);
      idle(12);
    end

    // R2 / R4 / R5: request order and refill
    do_reset();
    g0 = gcount;
    do_lookup(16'd1000, h, d, dc);
    check(h == 1'b0, "R1", "first lookup misses", h, 0);
    idle(12);
    check(gcount - g0 == 4, "R2", "requests after miss", gcount - g0, 4);
    for (int k = 0; k < 4; k++)
      check(glog[(g0 + k) % 1024] == AW'(1001 + k), "R2", $sformatf("request %0d address", k),
            glog[(g0 + k) % 1024], 1001 + k);
    do_lookup(16'd1001, h, d, dc);
    check(h == 1'b1 && d == line_data(16'd1001), "R3", "hit on 1001", d, line_data(16'd1001));
    idle(12);
    check(gcount - g0 == 5, "R4", "one request after hit", gcount - g0, 5);
    check(glog[(g0 + 4) % 1024] == 16'd1005, "R4", "tail refill address",
          glog[(g0 + 4) % 1024], 1005);
    do_lookup(16'd1003, h, d, dc);
    check(h == 1'b0, "R5", "non-head line misses", h, 0);
    idle(12);
    do_lookup(16'd1002, h, d, dc);
    check(h == 1'b1 && d == line_data(16'd1002), "R8", "recent stream kept", d,
          line_data(16'd1002));

    // R6 / R7: stall on pending head, many outstanding
    do_reset();
    lat = 15;
    watch_addr = 16'd2001;
    watch_cyc = -1;
    do_lookup(16'd2000, h, d, dc);
    do_lookup(16'd2001, h, d, dc);
    check(h == 1'b1 && d == line_data(16'd2001), "R6", "stalled hit data", d,
          line_data(16'd2001));
    check(dc - watch_cyc == 1, "R6", "done one cycle after response", dc - watch_cyc, 1);
    check(maxq >= 4, "R7", "outstanding requests", maxq, 4);
    idle(30);

    // R9: reload while old fetches outstanding
    do_reset();
    lat = 15;
    do_lookup(16'd3000, h, d, dc);
    do_lookup(16'd4000, h, d, dc);
    do_lookup(16'd5000, h, d, dc);
    check(h == 1'b0, "R9", "third miss", h, 0);
    for (int k = 1; k <= 4; k++) begin
      do_lookup(AW'(5000 + k), h, d, dc);
      check(h == 1'b1 && d == line_data(AW'(5000 + k)), "R9", $sformatf("new line %0d", 5000 + k),
            d, line_data(AW'(5000 + k)));
    end
    do_lookup(16'd4001, h, d, dc);
    check(h == 1'b1 && d == line_data(16'd4001), "R8", "other stream intact", d,
          line_data(16'd4001));
    idle(30);

    // R10: request held under backpressure
    do_reset();
    lat = 3;
    gnt_en = 0;
    g0 = gcount;
    do_lookup(16'd6000, h, d, dc);
    idle(2);
    for (int k = 0; k < 5; k++) begin
      #4;
      check(mem_req_o == 1'b1 && mem_addr_o == 16'd6001, "R10", "held request",
            mem_addr_o, 6001);
      @(negedge clk_i);
    end
    check(gcount == g0, "R10", "nothing accepted", gcount - g0, 0);
    gnt_en = 1;
    idle(15);
    do_lookup(16'd6001, h, d, dc);
    check(h == 1'b1 && d == line_data(16'd6001), "R10", "hit after release", d,
          line_data(16'd6001));

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule